// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block sits between a set of interrupt request lines and a processor core and decides which request the core takes next. Each request line is a vector number. Every source carries a two-bit priority level and can be switched off. Some sources have a level wired in, and others can be programmed within a limited band. Arbitration compares the level first, from 3 down to 0, and then the vector number, where the lowest number wins. The winner is presented as a pending flag, a vector number and a vector fetch address. That address is a programmable base plus two words per vector.

The block also tracks the level the core is now servicing. A new request is presented only when its level is above that serviced level, and level 3 always gets through. When the core acknowledges, the block latches the presented vector and its address for one cycle and raises the serviced level to the winner's level. The previous level goes onto a small stack. A return-from-interrupt pulse pops the stack to restore it. Vectors 0 and 1 are the reset entries and are never arbitrated.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_pending and ack_valid are low, the serviced level is idle (every level may be presented), and every programmable source (vectors 9 to 31) is off.
- R2: Among presentable requests, one with a higher level always wins over one with a lower level.
- R3: Among presentable requests at the same level, the lowest vector number wins.
- R4: vec_addr equals vec_base plus twice vec_num, modulo 2^AW, and ack_addr is the same for ack_vec.
- R5: Vectors 0 and 1 are never presented, whatever their request lines do.
- R6: Vectors 2 to 5 are fixed at level 3, vector 6 at level 2, vector 7 at level 1 and vector 8 at level 0. These sources are always on, and configuration writes to them have no effect.
- R7: A configuration write with cfg_we high sets source cfg_sel from cfg_code. Bit 2 set means off, and bits 1:0 give the level. Vectors 9 to 15 accept levels 1 to 3, so 0 is stored as 1. Vectors 16 to 24 accept levels 0 to 2, so 3 is stored as 2. Vectors 25 to 31 accept any level.
- R8: A source that is off never raises irq_pending.
- R9: A request is presented only if its level is strictly greater than the serviced level. Level 3 is always presented. An idle serviced level admits all levels.
- R10: ack while irq_pending is high gives ack_valid for exactly one cycle, with ack_vec and ack_addr equal to the presented vector. In that same following cycle irq_pending is low. The serviced level becomes the winner's level, and the old one is pushed onto a 4-entry stack. ack while irq_pending is low is ignored.
- R11: rti pops the stack into the serviced level. Popping an empty stack gives idle. A push onto a full stack discards the oldest entry.
- R12: ack (with irq_pending high) and rti in the same cycle set the serviced level to the winner's level and leave the stack contents unchanged.
- R13: irq_pending, vec_num and vec_addr are registered. They reflect the requests, levels and serviced level sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Request lines, bit index = vector number |
| cfg_we | input | 1 | Level configuration write strobe |
| cfg_sel | input | IW | Source written |
| cfg_code | input | 3 | Bit 2 = off, bits 1:0 = level |
| vec_base | input | AW | Vector table base address |
| ack | input | 1 | Core takes the presented interrupt |
| rti | input | 1 | Core returns from the current handler |
| irq_pending | output | 1 | An interrupt is presented |
| vec_num | output | IW | Presented vector number |
| vec_addr | output | AW | Presented vector fetch address |
| ack_valid | output | 1 | One-cycle strobe after an accepted ack |
| ack_vec | output | IW | Vector taken by the ack |
| ack_addr | output | AW | Fetch address of the vector taken |

## Verification
The acknowledge and the return-from-interrupt can fall in the same cycle. In that case the push and the pop must combine so that the serviced level becomes the winner's level and the stack is left as it was. The bench provokes this with a directed pulse of both strobes while a request is presented, and also leaves them free to coincide in the random phase. A bench-side model of the level table, serviced level and stack then predicts every later presentation, so a wrong stack or level shows up as a mismatched vector or pending flag several cycles on.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  // Lowest vector number that takes part in arbitration (0 and 1 are resets).
  localparam int FIRST_IRQ = 2;

  typedef enum logic [1:0] {
    RNG_FIXED = 2'd0,  // level wired in, never written
    RNG_HI    = 2'd1,  // levels 1..3
    RNG_LO    = 2'd2,  // levels 0..2
    RNG_ANY   = 2'd3   // levels 0..3
  } lvl_range_e;

  function automatic lvl_range_e range_of(int idx);
    if (idx < 9)       return RNG_FIXED;
    else if (idx < 16) return RNG_HI;
    else if (idx < 25) return RNG_LO;
    else               return RNG_ANY;
  endfunction

  function automatic logic [1:0] fixed_lvl(int idx);
    if (idx >= 2 && idx <= 5) return 2'd3;
    else if (idx == 6)        return 2'd2;
    else if (idx == 7)        return 2'd1;
    else                      return 2'd0;
  endfunction

  function automatic logic [1:0] clamp_lvl(lvl_range_e r, logic [1:0] l);
    if (r == RNG_HI && l == 2'd0)      return 2'd1;
    else if (r == RNG_LO && l == 2'd3) return 2'd2;
    else                               return l;
  endfunction

  // Serviced-level code: 0 = idle, n+1 = servicing level n.
  function automatic logic [2:0] svc_code(logic [1:0] l);
    return {1'b0, l} + 3'd1;
  endfunction

  function automatic logic eligible(logic [1:0] l, logic [2:0] mask);
    return (l == 2'd3) || (svc_code(l) > mask);
  endfunction

endpackage

// File: rtl/prio_intc_levels.sv
module prio_intc_levels
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IW = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IW-1:0]         sel,
  input  logic [2:0]            code,
  output logic [NSRC-1:0]       off,
  output logic [NSRC-1:0][1:0]  lvl
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i < FIRST_IRQ) begin : g_reset_vec
      assign off[i] = 1'b1;
      assign lvl[i] = 2'd0;
    end else if (range_of(i) == RNG_FIXED) begin : g_fixed
      assign off[i] = 1'b0;
      assign lvl[i] = fixed_lvl(i);
    end else begin : g_prog
      logic       off_q;
      logic [1:0] lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          off_q <= 1'b1;
          lvl_q <= 2'd0;
        end else if (we && sel == IW'(i)) begin
          off_q <= code[2];
          lvl_q <= clamp_lvl(range_of(i), code[1:0]);
        end
      end
      assign off[i] = off_q;
      assign lvl[i] = lvl_q;

      // R7: a stored level never leaves the source's allowed band
      a_r7_level_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        !off_q |-> ((range_of(i) != RNG_HI || lvl_q != 2'd0) &&
                    (range_of(i) != RNG_LO || lvl_q != 2'd3)));
    end
  end

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]       req,
  input  logic [NSRC-1:0]       off,
  input  logic [NSRC-1:0][1:0]  lvl,
  input  logic [2:0]            mask,
  output logic                  found,
  output logic [IW-1:0]         win_idx,
  output logic [1:0]            win_lvl
);

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = 2'd0;
    for (int i = NSRC - 1; i >= FIRST_IRQ; i--) begin
      if (req[i] && !off[i] && eligible(lvl[i], mask)) begin
        if (!found || lvl[i] >= win_lvl) begin
          found   = 1'b1;
          win_idx = IW'(i);
          win_lvl = lvl[i];
        end
      end
    end
  end

endmodule

// File: rtl/prio_intc_stack.sv
module prio_intc_stack #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  logic [2:0] new_mask,
  output logic [2:0] mask
);

  logic [2:0]    stk [DEPTH];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= 3'd0;
      cnt  <= '0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= 3'd0;
    end else if (push && pop) begin
      mask <= new_mask;
    end else if (push) begin
      mask   <= new_mask;
      stk[0] <= mask;
      for (int k = 1; k < DEPTH; k++) stk[k] <= stk[k-1];
      if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
    end else if (pop) begin
      mask <= stk[0];
      for (int k = 0; k < DEPTH - 1; k++) stk[k] <= stk[k+1];
      stk[DEPTH-1] <= 3'd0;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  // R11: depth never exceeds the stack size
  a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R11: popping an empty stack returns the serviced level to idle
  a_r11_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == '0) |=> (mask == 3'd0));

  // R12: simultaneous push and pop leave the depth alone
  a_r12_depth_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int AW      = 21,
  parameter int STACK_D = 4,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_sel,
  input  logic [2:0]      cfg_code,
  input  logic [AW-1:0]   vec_base,
  input  logic            ack,
  input  logic            rti,
  output logic            irq_pending,
  output logic [IW-1:0]   vec_num,
  output logic [AW-1:0]   vec_addr,
  output logic            ack_valid,
  output logic [IW-1:0]   ack_vec,
  output logic [AW-1:0]   ack_addr
);

  function automatic logic [AW-1:0] fetch_addr(logic [AW-1:0] base, logic [IW-1:0] idx);
    return base + (AW'(idx) << 1);
  endfunction

  logic [NSRC-1:0]      src_off;
  logic [NSRC-1:0][1:0] src_lvl;
  logic [2:0]           svc_mask;
  logic                 arb_found;
  logic [IW-1:0]        arb_idx;
  logic [1:0]           arb_lvl;
  logic [1:0]           win_lvl_q;
  logic                 ack_take;

  assign ack_take = ack && irq_pending;

  prio_intc_levels #(.NSRC(NSRC)) u_levels (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .code(cfg_code),
    .off(src_off), .lvl(src_lvl)
  );

  prio_intc_arb #(.NSRC(NSRC)) u_arb (
    .req(irq_req), .off(src_off), .lvl(src_lvl), .mask(svc_mask),
    .found(arb_found), .win_idx(arb_idx), .win_lvl(arb_lvl)
  );

  prio_intc_stack #(.DEPTH(STACK_D)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack_take), .pop(rti),
    .new_mask(svc_code(win_lvl_q)), .mask(svc_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pending <= 1'b0;
      vec_num     <= '0;
      vec_addr    <= '0;
      win_lvl_q   <= 2'd0;
      ack_valid   <= 1'b0;
      ack_vec     <= '0;
      ack_addr    <= '0;
    end else begin
      irq_pending <= arb_found && !ack_take;
      vec_num     <= arb_idx;
      vec_addr    <= fetch_addr(vec_base, arb_idx);
      win_lvl_q   <= arb_lvl;
      ack_valid   <= ack_take;
      if (ack_take) begin
        ack_vec  <= vec_num;
        ack_addr <= vec_addr;
      end
    end
  end

  // R5: reset vectors are never presented
  a_r5_no_reset_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (vec_num >= IW'(FIRST_IRQ)));

  // R4: presented address follows base plus two words per vector
  a_r4_addr_map: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (vec_addr == $past(vec_base) + (AW'(vec_num) << 1)));

  // R10: an accepted ack strobes once and silences the next cycle
  a_r10_ack_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (ack_valid && !irq_pending && ack_vec == $past(vec_num)));

  // R10: ack without a pending request is ignored
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_pending) |=> !ack_valid);

  // R10, R12: the serviced level follows the winner after an accepted ack
  a_r10_mask_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (svc_mask == svc_code($past(win_lvl_q))));

  // R9: a presented request was above the serviced level, or at level 3
  a_r9_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (win_lvl_q == 2'd3 || svc_code(win_lvl_q) > $past(svc_mask)));

endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;

  localparam int NSRC = 32;
  localparam int AW   = 21;
  localparam int IW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic            cfg_we = 1'b0;
  logic [IW-1:0]   cfg_sel = '0;
  logic [2:0]      cfg_code = '0;
  logic [AW-1:0]   vec_base = '0;
  logic            ack = 1'b0;
  logic            rti = 1'b0;
  logic            irq_pending, ack_valid;
  logic [IW-1:0]   vec_num, ack_vec;
  logic [AW-1:0]   vec_addr, ack_addr;

  always #10 clk = ~clk;  // 50 MHz

  prio_intc #(.NSRC(NSRC), .AW(AW), .STACK_D(4)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_code(cfg_code), .vec_base(vec_base),
    .ack(ack), .rti(rti), .irq_pending(irq_pending), .vec_num(vec_num),
    .vec_addr(vec_addr), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .ack_addr(ack_addr)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  string cur_tag  = "R1";

  // ---------------- reference model ----------------
  bit          m_off [NSRC];
  int          m_lvl [NSRC];
  int          m_mask;          // 0 idle, n+1 servicing level n
  int          m_stk [4];
  bit          m_pend, m_av;
  int          m_vec, m_wl, m_avec;
  bit [AW-1:0] m_addr, m_aaddr;

  function automatic bit [AW-1:0] addr_of(bit [AW-1:0] base, int v);
    return base + AW'(2 * v);
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NSRC; i++) begin
      m_off[i] = (i < 2) || (i > 8);
      case (i)
        2, 3, 4, 5: m_lvl[i] = 3;
        6:          m_lvl[i] = 2;
        7:          m_lvl[i] = 1;
        default:    m_lvl[i] = 0;
      endcase
    end
    m_mask = 0;
    for (int k = 0; k < 4; k++) m_stk[k] = 0;
    m_pend = 0; m_av = 0; m_vec = 0; m_wl = 0; m_avec = 0;
    m_addr = '0; m_aaddr = '0;
  endfunction

  // ascending scan, strict improvement: lowest index keeps a tie
  function automatic int model_pick(output int lv);
    int best = -1;
    lv = 0;
    for (int i = 2; i < NSRC; i++) begin
      if (irq_req[i] && !m_off[i] && (m_lvl[i] == 3 || m_lvl[i] + 1 > m_mask)) begin
        if (best < 0 || m_lvl[i] > lv) begin
          best = i;
          lv   = m_lvl[i];
        end
      end
    end
    return best;
  endfunction

  function automatic void model_edge();
    bit take = ack && m_pend;
    int w, wl;
    w = model_pick(wl);
    m_av = take;
    if (take) begin
      m_avec  = m_vec;
      m_aaddr = m_addr;
    end
    if (take && rti) begin
      m_mask = m_wl + 1;
    end else if (take) begin
      for (int k = 3; k > 0; k--) m_stk[k] = m_stk[k-1];
      m_stk[0] = m_mask;
      m_mask = m_wl + 1;
    end else if (rti) begin
      m_mask = m_stk[0];
      for (int k = 0; k < 3; k++) m_stk[k] = m_stk[k+1];
      m_stk[3] = 0;
    end
    m_pend = (w >= 0) && !take;
    if (w >= 0) begin
      m_vec  = w;
      m_wl   = wl;
      m_addr = addr_of(vec_base, w);
    end
    if (cfg_we) begin
      int s = int'(cfg_sel);
      int c = int'(cfg_code[1:0]);
      if (s >= 9) begin
        if (s <= 15 && c == 0) c = 1;
        if (s >= 16 && s <= 24 && c == 3) c = 2;
        m_off[s] = cfg_code[2];
        m_lvl[s] = c;
      end
    end
  endfunction

  // ---------------- checking ----------------
  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(irq_pending == m_pend, cur_tag, "irq_pending", irq_pending, m_pend);
    if (m_pend) begin
      check(vec_num == IW'(m_vec), cur_tag, "vec_num", vec_num, m_vec);
      check(vec_addr == m_addr, cur_tag, "vec_addr", vec_addr, m_addr);
    end
    check(ack_valid == m_av, cur_tag, "ack_valid", ack_valid, m_av);
    if (m_av) begin
      check(ack_vec == IW'(m_avec), cur_tag, "ack_vec", ack_vec, m_avec);
      check(ack_addr == m_aaddr, cur_tag, "ack_addr", ack_addr, m_aaddr);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic write_cfg(int idx, bit [2:0] code);
    cfg_we = 1'b1; cfg_sel = IW'(idx); cfg_code = code;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic take_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_rti();
    rti = 1'b1; step(); rti = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h1c0ffee5));
    model_reset();
    vec_base = 21'h01000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: quiet after reset
    cur_tag = "R1";
    check(irq_pending == 1'b0, "R1", "irq_pending after reset", irq_pending, 0);
    check(ack_valid == 1'b0, "R1", "ack_valid after reset", ack_valid, 0);

    // R8: source 20 is off after reset; request it
    cur_tag = "R8";
    irq_req = 32'h0010_0000;
    step(); step();
    check(irq_pending == 1'b0, "R8", "off source pending", irq_pending, 0);

    // R13, R4: enable 20 at level 1, output one edge later
    cur_tag = "R13";
    irq_req = '0;
    write_cfg(20, 3'b001);
    irq_req = 32'h0010_0000;
    check(irq_pending == 1'b0, "R13", "pending before edge", irq_pending, 0);
    step();
    check(irq_pending && vec_num == 5'd20, "R13", "vec one edge later", vec_num, 20);
    check(vec_addr == 21'h01028, "R4", "vec_addr of 20", vec_addr, 21'h01028);

    // R2: level 2 source 27 beats level 1 source 20
    cur_tag = "R2";
    write_cfg(27, 3'b010);
    irq_req = 32'h0810_0000;
    step();
    check(vec_num == 5'd27, "R2", "higher level wins", vec_num, 27);

    // R3: 26 at level 2 beats 27 at level 2
    cur_tag = "R3";
    write_cfg(26, 3'b010);
    irq_req = 32'h0C10_0000;
    step();
    check(vec_num == 5'd26, "R3", "lower number wins tie", vec_num, 26);

    // R5: reset vectors alone
    cur_tag = "R5";
    irq_req = 32'h0000_0003;
    step(); step();
    check(irq_pending == 1'b0, "R5", "reset vectors pending", irq_pending, 0);

    // R6: write "off" to fixed source 8, it still presents at level 0
    cur_tag = "R6";
    write_cfg(8, 3'b100);
    irq_req = 32'h0000_0100;
    step();
    check(irq_pending && vec_num == 5'd8, "R6", "fixed source 8", vec_num, 8);
    // fixed 7 (level 1) beats fixed 8 (level 0); 2 (level 3) beats everything
    irq_req = 32'h0000_0180;
    step();
    check(vec_num == 5'd7, "R6", "fixed 7 over 8", vec_num, 7);

    // R7: 16 written 3 stores 2, so 25 at level 3 wins
    cur_tag = "R7";
    irq_req = '0;
    write_cfg(16, 3'b011);
    write_cfg(25, 3'b011);
    irq_req = 32'h0201_0000;
    step();
    check(vec_num == 5'd25, "R7", "clamp 3 to 2", vec_num, 25);
    // 9 written 0 stores 1, so it beats 25 at level 1
    irq_req = '0;
    write_cfg(9, 3'b000);
    write_cfg(25, 3'b001);
    irq_req = 32'h0200_0200;
    step();
    check(vec_num == 5'd9, "R7", "clamp 0 to 1", vec_num, 9);

    // R10: take 20 (level 1)
    cur_tag = "R10";
    write_cfg(9, 3'b100);
    write_cfg(25, 3'b100);
    irq_req = 32'h0010_0000;
    step();
    take_ack();
    check(ack_valid && ack_vec == 5'd20, "R10", "ack_vec", ack_vec, 20);
    check(irq_pending == 1'b0, "R10", "quiet after ack", irq_pending, 0);
    step();
    check(ack_valid == 1'b0, "R10", "ack strobe one cycle", ack_valid, 0);

    // R9: 20 at level 1 is now masked; 27 at level 2 is above it
    cur_tag = "R9";
    check(irq_pending == 1'b0, "R9", "same level masked", irq_pending, 0);
    irq_req = 32'h0810_0000;
    step();
    check(vec_num == 5'd27, "R9", "higher level passes", vec_num, 27);
    take_ack(); step();
    irq_req = 32'h0000_0004;       // fixed level 3
    step();
    take_ack(); step();
    irq_req = 32'h0000_0008;       // level 3 while servicing level 3
    step();
    check(irq_pending && vec_num == 5'd3, "R9", "level 3 always", vec_num, 3);

    // R11: overfill the stack, then unwind past empty
    cur_tag = "R11";
    take_ack(); step();
    irq_req = 32'h0000_0010;
    step(); take_ack(); step();
    irq_req = 32'h0000_0020;
    step(); take_ack(); step();
    irq_req = 32'h0010_0000;
    for (int k = 0; k < 6; k++) begin
      do_rti();
      step();
    end

    // R12: ack and rti together
    cur_tag = "R12";
    irq_req = 32'h0800_0000;
    step();
    ack = 1'b1; rti = 1'b1;
    step();
    ack = 1'b0; rti = 1'b0;
    irq_req = 32'h0810_0000;
    step(); step();
    do_rti(); step(); step();

    // R10: ack with nothing pending is ignored
    cur_tag = "R10";
    irq_req = '0;
    step(); step();
    take_ack();
    check(ack_valid == 1'b0, "R10", "idle ack ignored", ack_valid, 0);

    // Random phase: R2 R3 R4 R9 R11 R12 against the model
    cur_tag = "R9";
    for (int n = 0; n < 4000; n++) begin
      irq_req = $urandom & $urandom & $urandom;
      cfg_we  = ($urandom % 6) == 0;
      cfg_sel = IW'($urandom);
      cfg_code = 3'($urandom) & ((($urandom % 4) == 0) ? 3'b111 : 3'b011);
      ack     = ($urandom % 4) == 0;
      rti     = ($urandom % 5) == 0;
      if (($urandom % 200) == 0) vec_base = AW'($urandom);
      step();
    end
    cfg_we = 1'b0; ack = 1'b0; rti = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule